// File: doc/BRIEF.md
# Battery Pack Switch Protection Controller

This block controls the charge and discharge switches of a battery pack on behalf of a host microcontroller. The host writes a switch-control register and a discharge-protection register through a one-cycle write port, and can read any register back through a combinational read port. Three digitized comparator flags come in: discharge overcurrent, discharge short circuit and charge overcurrent. The block turns each flag into a fault event, latches status, clears the affected switch enable, and drives the switch, monitor-enable, balance, analog-select and fault-indicator outputs.

The discharge overcurrent flag has to stay high for a programmable number of time-base ticks before it counts as a fault. Ticks arrive once every half millisecond. The number of ticks doubles with each step of a 2-bit code, and a fast-range input selects the short set of delays. The short-circuit and charge-overcurrent flags only pass a fixed debounce measured in clock cycles. A per-fault disable stops the automatic switch-off but leaves the status latch working. The host can force the block into sleep. A wake event ends sleep.

Top module: `bpf_ctrl`

## Requirements
- R1: After reset every register reads 0, and every output is 0.
- R2: Register map, 8-bit data. Address 0 is switch control: bit0 is the charge enable, bit1 the discharge enable, bit2 the monitor enable, bit3 sleep, and bits 7:4 read 0. Address 1 is discharge protection: bits 1:0 are the overcurrent threshold code, bits 3:2 the overcurrent delay code, bits 5:4 the short-circuit threshold code, bit6 keeps the discharge switch on for short circuits, and bit7 keeps it on for overcurrents. This register reads back all 8 bits. The two threshold codes drive `oc_thr` and `sc_thr`. Address 2 is status: bit0 is the overcurrent latch and bit1 the short-circuit latch. Address 3 holds the balance enables in bits 6:0, and bit 7 reads 0. Address 4 holds the analog select in bits 3:0. Addresses 5 to 7 read 0.
- R3: `oc_flag` becomes a qualified fault on the tick that makes it the D-th tick seen while the flag has stayed high without a break. D is SLOW_BASE<<code, or FAST_BASE<<code when `fast_div` is 1. Any cycle with the flag low restarts the count.
- R4: A qualified overcurrent sets status bit0 whatever the value of protection bit7. It clears the discharge enable only when bit7 is 0.
- R5: When `sc_flag` is high for SC_DEB consecutive clock cycles, status bit1 is set. The discharge enable is cleared only when protection bit6 is 0.
- R6: When `coc_flag` is high for SC_DEB consecutive cycles, the charge enable is cleared, unless `coc_keep` is 1.
- R7: `fault_ind` is 1 exactly when status bit0 or status bit1 is set.
- R8: A status bit stays set until the host writes 1 to it at address 2. If a fault and that write land in the same cycle, the fault wins. If a fault clears an enable in the same cycle as a host write that sets it, the fault wins.
- R9: Writing 1 to switch-control bit3 enters sleep. On entry the charge enable, the discharge enable and the balance enables are cleared. The analog select and the protection register keep their values. While asleep, writes to those enables are ignored, and `chg_fet`, `dsg_fet` and `asleep` reflect the sleep state.
- R10: A `wake` pulse clears the sleep bit, and the host cannot clear it. After wake the switch enables stay 0 until the host writes them.
- R11: While awake, `chg_fet` and `dsg_fet` follow the charge and discharge enables, and `mon_en` follows bit2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |
| tick | input | 1 | Time-base pulse, one every 0.5 ms |
| fast_div | input | 1 | Selects the short overcurrent delay range |
| oc_flag | input | 1 | Discharge overcurrent comparator flag |
| sc_flag | input | 1 | Discharge short-circuit comparator flag |
| coc_flag | input | 1 | Charge overcurrent comparator flag |
| coc_keep | input | 1 | Disables automatic charge switch-off |
| wake | input | 1 | Wake event |
| chg_fet | output | 1 | Charge switch drive |
| dsg_fet | output | 1 | Discharge switch drive |
| mon_en | output | 1 | Monitor enable |
| fault_ind | output | 1 | Latched discharge fault indicator |
| asleep | output | 1 | Sleep state |
| oc_thr | output | 2 | Overcurrent threshold code |
| sc_thr | output | 2 | Short-circuit threshold code |
| bal_en | output | 7 | Cell balance enables |
| aout_sel | output | 4 | Analog output select |

## Verification
The bench builds the block with SLOW_BASE=6, FAST_BASE=2 and SC_DEB=3. The longest overcurrent delay is then 48 ticks. This makes it cheap to sweep every delay code in both ranges against both settings of the auto-off bit, checking one tick before and exactly at the threshold each time. All 256 protection-register values are written and read back. Debounce edges, same-cycle collisions between host writes and faults, and the whole sleep-and-wake sequence are each driven cycle by cycle.

// File: rtl/bpf_pkg.sv
package bpf_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_PROT = 3'd1,
    A_STAT = 3'd2,
    A_BAL  = 3'd3,
    A_AOUT = 3'd4
  } reg_addr_e;

  // switch-control bit positions
  localparam int B_CHG   = 0;
  localparam int B_DSG   = 1;
  localparam int B_MON   = 2;
  localparam int B_SLEEP = 3;

  // protection register bit positions
  localparam int B_SC_KEEP = 6;
  localparam int B_OC_KEEP = 7;

  // status bit positions
  localparam int B_DOC = 0;
  localparam int B_SCD = 1;

  // overcurrent qualification length in ticks
  function automatic int oc_delay(input logic [1:0] code, input logic fast,
                                  input int slow_base, input int fast_base);
    int base;
    base = fast ? fast_base : slow_base;
    return base << code;
  endfunction

endpackage

// File: rtl/bpf_qual.sv
module bpf_qual #(
  parameter int SLOW_BASE = 320,
  parameter int FAST_BASE = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flag_i,
  input  logic       tick_i,
  input  logic [1:0] code_i,
  input  logic       fast_i,
  output logic       hit_o
);
  localparam int MAXD = ((SLOW_BASE > FAST_BASE) ? SLOW_BASE : FAST_BASE) * 8;
  localparam int CW   = $clog2(MAXD + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [CW:0]   delay_w;
  logic [CW:0]   next_w;

  assign delay_w = (CW+1)'(bpf_pkg::oc_delay(code_i, fast_i, SLOW_BASE, FAST_BASE));
  assign next_w  = {1'b0, cnt_q} + 1'b1;
  assign hit_o   = flag_i && tick_i && !done_q && (next_w >= delay_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!flag_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick_i && !done_q) begin
      if (hit_o) done_q <= 1'b1;
      else       cnt_q  <= next_w[CW-1:0];
    end
  end

  // a qualified event only comes from a tick with the flag still high
  p_hit_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (flag_i && tick_i));
  // a dropped flag always restarts the count
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_i |=> (cnt_q == '0) && !done_q);
  // one event per continuous assertion
  p_one_shot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);

endmodule

// File: rtl/bpf_debounce.sv
module bpf_debounce #(
  parameter int DEB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  output logic hit_o
);
  localparam int CW = $clog2(DEB + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign hit_o = flag_i && !done_q && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!flag_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (hit_o) done_q <= 1'b1;
      else       cnt_q  <= cnt_q + 1'b1;
    end
  end

  p_deb_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);
  p_deb_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> flag_i);

endmodule

// File: rtl/bpf_regs.sv
module bpf_regs #(
  parameter int BAL_N  = 7,
  parameter int AOUT_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [bpf_pkg::ADDR_W-1:0]  wr_addr,
  input  logic [bpf_pkg::DATA_W-1:0]  wr_data,
  input  logic [bpf_pkg::ADDR_W-1:0]  rd_addr,
  output logic [bpf_pkg::DATA_W-1:0]  rd_data,
  input  logic                        oc_hit,
  input  logic                        sc_hit,
  input  logic                        coc_hit,
  input  logic                        coc_keep,
  input  logic                        wake,
  output logic                        chg_en,
  output logic                        dsg_en,
  output logic                        mon_q,
  output logic                        sleep_q,
  output logic [bpf_pkg::DATA_W-1:0]  prot_q,
  output logic                        st_doc,
  output logic                        st_scd,
  output logic [BAL_N-1:0]            bal_q,
  output logic [AOUT_W-1:0]           aout_q
);
  import bpf_pkg::*;

  logic wr_ctrl, wr_prot, wr_stat, wr_bal, wr_aout;
  logic sleep_set, hold_off;
  logic dsg_kill, chg_kill;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_prot = wr_en && (wr_addr == A_PROT);
  assign wr_stat = wr_en && (wr_addr == A_STAT);
  assign wr_bal  = wr_en && (wr_addr == A_BAL);
  assign wr_aout = wr_en && (wr_addr == A_AOUT);

  assign sleep_set = wr_ctrl && wr_data[B_SLEEP];
  assign hold_off  = sleep_q || sleep_set;
  assign dsg_kill  = (oc_hit && !prot_q[B_OC_KEEP]) || (sc_hit && !prot_q[B_SC_KEEP]);
  assign chg_kill  = coc_hit && !coc_keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_en  <= 1'b0;
      dsg_en  <= 1'b0;
      mon_q   <= 1'b0;
      sleep_q <= 1'b0;
      prot_q  <= '0;
      st_doc  <= 1'b0;
      st_scd  <= 1'b0;
      bal_q   <= '0;
      aout_q  <= '0;
    end else begin
      // switch enables: sleep, then faults, then host
      if (hold_off)      chg_en <= 1'b0;
      else if (chg_kill) chg_en <= 1'b0;
      else if (wr_ctrl)  chg_en <= wr_data[B_CHG];

      if (hold_off)      dsg_en <= 1'b0;
      else if (dsg_kill) dsg_en <= 1'b0;
      else if (wr_ctrl)  dsg_en <= wr_data[B_DSG];

      if (wr_ctrl) mon_q <= wr_data[B_MON];

      // sleep: set by host only, cleared by wake only
      if (sleep_set)  sleep_q <= 1'b1;
      else if (wake)  sleep_q <= 1'b0;

      if (wr_prot) prot_q <= wr_data;

      // latched status: set wins over write-one-to-clear
      if (oc_hit)                        st_doc <= 1'b1;
      else if (wr_stat && wr_data[B_DOC]) st_doc <= 1'b0;
      if (sc_hit)                        st_scd <= 1'b1;
      else if (wr_stat && wr_data[B_SCD]) st_scd <= 1'b0;

      if (hold_off)    bal_q <= '0;
      else if (wr_bal) bal_q <= wr_data[BAL_N-1:0];

      if (wr_aout) aout_q <= wr_data[AOUT_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL: begin
        rd_data[B_CHG]   = chg_en;
        rd_data[B_DSG]   = dsg_en;
        rd_data[B_MON]   = mon_q;
        rd_data[B_SLEEP] = sleep_q;
      end
      A_PROT: rd_data = prot_q;
      A_STAT: begin
        rd_data[B_DOC] = st_doc;
        rd_data[B_SCD] = st_scd;
      end
      A_BAL:  rd_data[BAL_N-1:0]  = bal_q;
      A_AOUT: rd_data[AOUT_W-1:0] = aout_q;
      default: rd_data = '0;
    endcase
  end

  p_doc_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oc_hit |=> st_doc);
  p_oc_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_hit && !prot_q[B_OC_KEEP]) |=> !dsg_en);
  p_sc_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_hit && !prot_q[B_SC_KEEP]) |=> (!dsg_en && st_scd));
  p_coc_kill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (coc_hit && !coc_keep) |=> !chg_en);
  p_doc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_doc && !(wr_stat && wr_data[B_DOC])) |=> st_doc);
  p_sleep_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_q) |-> (!chg_en && !dsg_en && (bal_q == '0) && $stable(aout_q)));
  p_asleep_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |=> (!chg_en && !dsg_en));
  p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && wake && !sleep_set) |=> !sleep_q);

endmodule

// File: rtl/bpf_ctrl.sv
module bpf_ctrl #(
  parameter int SLOW_BASE = 320,
  parameter int FAST_BASE = 5,
  parameter int SC_DEB    = 4,
  parameter int BAL_N     = 7,
  parameter int AOUT_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [bpf_pkg::ADDR_W-1:0] wr_addr,
  input  logic [bpf_pkg::DATA_W-1:0] wr_data,
  input  logic [bpf_pkg::ADDR_W-1:0] rd_addr,
  output logic [bpf_pkg::DATA_W-1:0] rd_data,
  input  logic                       tick,
  input  logic                       fast_div,
  input  logic                       oc_flag,
  input  logic                       sc_flag,
  input  logic                       coc_flag,
  input  logic                       coc_keep,
  input  logic                       wake,
  output logic                       chg_fet,
  output logic                       dsg_fet,
  output logic                       mon_en,
  output logic                       fault_ind,
  output logic                       asleep,
  output logic [1:0]                 oc_thr,
  output logic [1:0]                 sc_thr,
  output logic [BAL_N-1:0]           bal_en,
  output logic [AOUT_W-1:0]          aout_sel
);
  logic oc_hit, sc_hit, coc_hit;
  logic chg_en, dsg_en, mon_q, sleep_q, st_doc, st_scd;
  logic [bpf_pkg::DATA_W-1:0] prot_q;

  bpf_qual #(.SLOW_BASE(SLOW_BASE), .FAST_BASE(FAST_BASE)) u_oc (
    .clk(clk), .rst_n(rst_n), .flag_i(oc_flag), .tick_i(tick),
    .code_i(prot_q[3:2]), .fast_i(fast_div), .hit_o(oc_hit));

  bpf_debounce #(.DEB(SC_DEB)) u_sc (
    .clk(clk), .rst_n(rst_n), .flag_i(sc_flag), .hit_o(sc_hit));

  bpf_debounce #(.DEB(SC_DEB)) u_coc (
    .clk(clk), .rst_n(rst_n), .flag_i(coc_flag), .hit_o(coc_hit));

  bpf_regs #(.BAL_N(BAL_N), .AOUT_W(AOUT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .oc_hit(oc_hit), .sc_hit(sc_hit), .coc_hit(coc_hit),
    .coc_keep(coc_keep), .wake(wake),
    .chg_en(chg_en), .dsg_en(dsg_en), .mon_q(mon_q), .sleep_q(sleep_q),
    .prot_q(prot_q), .st_doc(st_doc), .st_scd(st_scd),
    .bal_q(bal_q_w), .aout_q(aout_sel));

  logic [BAL_N-1:0] bal_q_w;

  assign chg_fet   = chg_en && !sleep_q;
  assign dsg_fet   = dsg_en && !sleep_q;
  assign mon_en    = mon_q;
  assign asleep    = sleep_q;
  assign fault_ind = st_doc || st_scd;
  assign oc_thr    = prot_q[1:0];
  assign sc_thr    = prot_q[5:4];
  assign bal_en    = sleep_q ? '0 : bal_q_w;

  p_fet_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!chg_fet && !dsg_fet && (bal_en == '0)));
  p_fault_ind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_hit || oc_hit) |=> fault_ind);

endmodule

// File: tb/bpf_ctrl_test.sv
module bpf_ctrl_test;
  localparam int SLOW = 6;
  localparam int FAST = 2;
  localparam int DEB  = 3;

  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, tick = 0, fast_div = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic       oc_flag = 0, sc_flag = 0, coc_flag = 0, coc_keep = 0, wake = 0;
  logic       chg_fet, dsg_fet, mon_en, fault_ind, asleep;
  logic [1:0] oc_thr, sc_thr;
  logic [6:0] bal_en;
  logic [3:0] aout_sel;

  int checks = 0, errors = 0;
  bit done = 0;

  bpf_ctrl #(.SLOW_BASE(SLOW), .FAST_BASE(FAST), .SC_DEB(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .fast_div(fast_div),
    .oc_flag(oc_flag), .sc_flag(sc_flag), .coc_flag(coc_flag), .coc_keep(coc_keep),
    .wake(wake), .chg_fet(chg_fet), .dsg_fet(dsg_fet), .mon_en(mon_en),
    .fault_ind(fault_ind), .asleep(asleep), .oc_thr(oc_thr), .sc_thr(sc_thr),
    .bal_en(bal_en), .aout_sel(aout_sel));

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic tk();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R1 reg after reset", v, 0);
    end
    chk("R1 outputs after reset",
        {chg_fet, dsg_fet, mon_en, fault_ind, asleep, oc_thr, sc_thr, bal_en, aout_sel}, 0);
    rst_n = 1;

    // R2 register map
    for (int d = 0; d < 256; d++) begin
      wr(3'd1, 8'(d)); rd(3'd1, v);
      chk("R2 prot readback", v, d);
      chk("R2 threshold outputs", {oc_thr, sc_thr}, {d[1:0], d[5:4]});
    end
    wr(3'd0, 8'hF4); rd(3'd0, v); chk("R2 ctrl reserved bits", v, 8'h04);
    chk("R11 mon_en follows bit2", mon_en, 1);
    wr(3'd3, 8'hFF); rd(3'd3, v); chk("R2 balance width", v, 8'h7F);
    chk("R2 bal_en output", bal_en, 7'h7F);
    wr(3'd4, 8'hFA); rd(3'd4, v); chk("R2 aout width", v, 8'h0A);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v); chk("R2 unmapped reads 0", v, 0);
    end
    wr(3'd0, 8'h03);
    chk("R11 fets follow enables", {chg_fet, dsg_fet}, 2'b11);

    // R3/R4 overcurrent sweep
    for (int dv = 0; dv < 2; dv++)
      for (int code = 0; code < 4; code++)
        for (int keep = 0; keep < 2; keep++) begin
          int dly;
          dly = (dv ? FAST : SLOW) << code;
          fast_div = dv[0];
          wr(3'd2, 8'h03);
          wr(3'd0, 8'h03);
          wr(3'd1, {keep[0], 1'b0, 2'b00, code[1:0], 2'b01});
          @(negedge clk); oc_flag = 1;
          repeat (dly - 1) tk();
          rd(3'd2, v);
          chk("R3 no fault before delay", v[0], 0);
          chk("R4 dsg on before delay", dsg_fet, 1);
          tk();
          rd(3'd2, v);
          chk("R3 fault at delay", v[0], 1);
          chk("R4 dsg after fault", dsg_fet, keep);
          chk("R7 fault_ind on DOC", fault_ind, 1);
          @(negedge clk); oc_flag = 0;
        end

    // R3 restart on dropped flag (fast range, code 1 => 4 ticks)
    fast_div = 1;
    wr(3'd2, 8'h03); wr(3'd0, 8'h03); wr(3'd1, 8'h04);
    chk("R7 fault_ind clear", fault_ind, 0);
    @(negedge clk); oc_flag = 1;
    repeat (3) tk();
    @(negedge clk); oc_flag = 0;
    @(negedge clk); oc_flag = 1;
    repeat (3) tk();
    rd(3'd2, v); chk("R3 restart no fault", v[0], 0);
    tk();
    rd(3'd2, v); chk("R3 restart fault", v[0], 1);
    chk("R4 dsg cleared", dsg_fet, 0);
    @(negedge clk); oc_flag = 0;
    // R8 status holds until written one
    wr(3'd2, 8'h02); rd(3'd2, v); chk("R8 DOC holds on other bit", v[0], 1);
    wr(3'd2, 8'h01); rd(3'd2, v); chk("R8 DOC cleared by W1C", v[0], 0);

    // R5 short circuit
    for (int keep = 0; keep < 2; keep++) begin
      wr(3'd2, 8'h03); wr(3'd0, 8'h03); wr(3'd1, {1'b0, keep[0], 6'h0});
      @(negedge clk); sc_flag = 1;
      repeat (DEB - 1) @(negedge clk);
      rd(3'd2, v); chk("R5 no SCD before debounce", v[1], 0);
      @(negedge clk);
      rd(3'd2, v); chk("R5 SCD set", v[1], 1);
      chk("R5 dsg after SC", dsg_fet, keep);
      chk("R7 fault_ind on SCD", fault_ind, 1);
      sc_flag = 0;
    end
    // R5 glitch: break resets debounce
    wr(3'd2, 8'h03);
    @(negedge clk); sc_flag = 1;
    repeat (DEB - 1) @(negedge clk);
    sc_flag = 0; @(negedge clk); sc_flag = 1;
    repeat (DEB - 1) @(negedge clk);
    rd(3'd2, v); chk("R5 glitch no SCD", v[1], 0);
    sc_flag = 0;

    // R8 fault vs W1C same cycle
    wr(3'd1, 8'h00); wr(3'd0, 8'h03);
    @(negedge clk); sc_flag = 1;
    repeat (DEB - 1) @(negedge clk);
    wr_en = 1; wr_addr = 3'd2; wr_data = 8'h02;
    @(negedge clk); wr_en = 0;
    rd(3'd2, v); chk("R8 set wins over W1C", v[1], 1);
    sc_flag = 0;
    // R8 fault vs enable write same cycle
    @(negedge clk); sc_flag = 1;
    repeat (DEB - 1) @(negedge clk);
    wr_en = 1; wr_addr = 3'd0; wr_data = 8'h03;
    @(negedge clk); wr_en = 0;
    chk("R8 fault wins over enable write", {chg_fet, dsg_fet}, 2'b10);
    sc_flag = 0;

    // R6 charge overcurrent
    for (int keep = 0; keep < 2; keep++) begin
      coc_keep = keep[0];
      wr(3'd0, 8'h03);
      @(negedge clk); coc_flag = 1;
      repeat (DEB - 1) @(negedge clk);
      chk("R6 chg on before debounce", chg_fet, 1);
      @(negedge clk);
      chk("R6 chg after COC", chg_fet, keep);
      chk("R6 dsg untouched", dsg_fet, 1);
      coc_flag = 0;
    end
    coc_keep = 0;

    // R9 sleep
    wr(3'd2, 8'h03);
    wr(3'd3, 8'h55); wr(3'd4, 8'h09); wr(3'd1, 8'hA6); wr(3'd0, 8'h07);
    wr(3'd0, 8'h0F);
    rd(3'd0, v); chk("R9 ctrl after sleep entry", v, 8'h0C);
    rd(3'd3, v); chk("R9 balance cleared", v, 0);
    rd(3'd4, v); chk("R9 aout kept", v, 8'h09);
    rd(3'd1, v); chk("R9 prot kept", v, 8'hA6);
    chk("R9 outputs asleep", {asleep, chg_fet, dsg_fet, bal_en, aout_sel}, {3'b100, 7'h0, 4'h9});
    wr(3'd0, 8'h03); wr(3'd3, 8'h7F);
    rd(3'd0, v); chk("R10 host cannot clear sleep; R9 enables ignored", v, 8'h08);
    rd(3'd3, v); chk("R9 balance write ignored", v, 0);
    chk("R9 fets off asleep", {chg_fet, dsg_fet}, 0);

    // R10 wake
    @(negedge clk); wake = 1;
    @(negedge clk); wake = 0;
    rd(3'd0, v); chk("R10 wake clears sleep", v, 8'h00);
    chk("R10 fets stay off after wake", {asleep, chg_fet, dsg_fet}, 0);
    wr(3'd0, 8'h03);
    chk("R10 host re-enables", {chg_fet, dsg_fet}, 2'b11);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule